// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Unit

This unit holds the status register of a small serial flash and decides which write operations may go ahead. The command decoder feeds it one-cycle events: set or clear the write-enable latch, program, sector erase, block erase, chip erase and status write (with its data byte). It also receives the target address, the chip-select rising edge and the write-protect pin, which is active low. It answers with the status byte, a busy flag, a writable flag for a query address, a per-sector writable vector for the array, and a one-cycle start pulse with an operation code when a self-timed cycle begins.

A write command that passes its checks is held pending until chip-select rises. The cycle then runs for a parameterised number of system clocks. Four block-protect bits choose a locked region at the top of the array. Some combinations of these bits are treated as don't-care. A hardware lock forms when the pin is low and the protect-enable bit is set. While that lock is present, status writes are refused. A status write that is still pending is cancelled if the lock appears before the cycle starts.

The controller is a three-state machine. The states are ST_IDLE, ST_ARMED (a granted write is waiting for chip-select to rise) and ST_CYCLE (the internal cycle is running). The transitions are:
- ARM: ST_IDLE to ST_ARMED, on a granted write command.
- REARM: ST_ARMED to ST_ARMED, when a new granted command replaces the pending one.
- ABORT: ST_ARMED to ST_IDLE, when a pending status write meets the hardware lock.
- LAUNCH: ST_ARMED to ST_CYCLE, when chip-select rises.
- DONE: ST_CYCLE to ST_IDLE, when the cycle timer expires.

Top module: `sr_wp_unit`

## Requirements
- R1: After reset the status byte is 00h, busy is low, and every address and every sector reads as writable.
- R2: When not busy, the status byte has these fields: bit 7 protect-enable, bit 6 BP4, bit 5 BP3, bit 3 BP1, bit 2 BP0, bit 1 write-enable latch. Bit 4 and bit 0 read 0. A status write stores only data bits 7, 6, 5, 3 and 2.
- R3: A set-latch event sets the write-enable latch. A clear-latch event clears it whatever the level of the write-protect pin.
- R4: The protect code {BP4,BP3,BP1,BP0} selects the locked region, with x meaning don't-care. 0000 locks nothing. 0100 locks 1F000h-1FFFFh. 1000 locks 1E000h-1FFFFh. 1100 locks 1C000h-1FFFFh. xx01 locks 18000h-1FFFFh. xx10 locks 10000h-1FFFFh. xx11 locks the whole array. The query output and the per-sector vector (bit s for 4 KB sector s) follow this decode.
- R5: A write command with the latch clear starts no cycle. The latch is cleared when any internal cycle completes.
- R6: A granted command starts its cycle on the chip-select rising edge. busy_o is then high for exactly the configured number of clocks for that operation. In that first cycle cycle_start_o pulses and cycle_op_o gives the operation code: 1 program, 2 sector erase, 3 block erase, 4 chip erase, 5 status write.
- R7: A status write is refused while the pin is low and protect-enable is 1. A pending status write is cancelled if that lock appears before chip-select rises. A pin change after the cycle has started does not affect the write. While protect-enable is 0 the pin has no effect.
- R8: Program, sector erase (4 KB) and block erase (32 KB) are refused when the region they target contains a locked byte. Any address inside the region selects that region.
- R9: While busy, the status byte reads FFh and all command events are ignored.
- R10: Chip erase is granted whenever the latch is set. The array skips locked sectors by following the per-sector vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Set write-enable latch event |
| wrdi_i | input | 1 | Clear write-enable latch event |
| prog_i | input | 1 | Program command event |
| sect_erase_i | input | 1 | Sector erase command event |
| blk_erase_i | input | 1 | Block erase command event |
| chip_erase_i | input | 1 | Chip erase command event |
| wrsr_i | input | 1 | Status write event, data on wrsr_data_i |
| wrsr_data_i | input | 8 | Status write data byte |
| cmd_addr_i | input | ADDR_W | Target address of the command |
| cs_rise_i | input | 1 | Chip-select rising-edge event |
| wp_n_i | input | 1 | Write-protect pin, low active |
| query_addr_i | input | ADDR_W | Address whose writability is reported |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Internal cycle in progress |
| addr_writable_o | output | 1 | Query address lies outside the locked region |
| sector_writable_o | output | NUM_SECT | Per-sector writable flags |
| cycle_start_o | output | 1 | One-cycle pulse in the first busy cycle |
| cycle_op_o | output | 3 | Code of the running operation |
| cycle_addr_o | output | ADDR_W | Target address of the running operation |

## Verification
A command event sampled at one clock edge changes the status byte and the state by the next edge. The bench therefore drives every event for one cycle between falling edges and reads the outputs at the following falling edge. The chip-select edge that launches a cycle raises busy_o and cycle_start_o after that same clock edge, so both are checked at the falling edge right after the launch pulse. From that falling edge the bench counts the falling edges on which busy_o is high and compares the count with the configured length. The query and sector outputs are combinational, so the bench checks them 1 time unit after it changes the address.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PROG = 3'd1,
        OP_SECT = 3'd2,
        OP_BLK  = 3'd3,
        OP_CHIP = 3'd4,
        OP_STAT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CYCLE = 2'd2
    } state_e;

    // Non-volatile part of the status register.
    typedef struct packed {
        logic wpen;
        logic bp4;
        logic bp3;
        logic bp1;
        logic bp0;
    } sreg_t;

    // Locked region: enabled flag plus count of top address bits that must be ones.
    typedef struct packed {
        logic       en;
        logic [2:0] span;
    } prot_t;

    localparam int TOP_BITS = 5;

    // code = {bp4, bp3, bp1, bp0}
    function automatic prot_t prot_of(input logic [3:0] code);
        prot_t p;
        p.en   = 1'b1;
        p.span = 3'd0;
        unique case (code[1:0])
            2'b11: p.span = 3'd0;
            2'b10: p.span = 3'd1;
            2'b01: p.span = 3'd2;
            default: begin
                unique case (code[3:2])
                    2'b11:   p.span = 3'd3;
                    2'b10:   p.span = 3'd4;
                    2'b01:   p.span = 3'd5;
                    default: p.en   = 1'b0;
                endcase
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/srwp_lock_decode.sv
module srwp_lock_decode
    import srwp_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int SECTOR_AW = 12
) (
    input  logic [3:0]          code_i,
    input  logic [ADDR_W-1:0]   probe_addr_i,
    input  logic [ADDR_W-1:0]   query_addr_i,
    output logic                probe_locked_o,
    output logic                query_locked_o,
    output logic [(1 << (ADDR_W-SECTOR_AW))-1:0] sector_locked_o
);
    localparam int NUM_SECT = 1 << (ADDR_W - SECTOR_AW);
    localparam int LOW_W    = ADDR_W - TOP_BITS;

    prot_t prot;
    assign prot = prot_of(code_i);

    function automatic logic hit(input prot_t p, input logic [TOP_BITS-1:0] top);
        logic r;
        r = p.en;
        for (int i = 0; i < TOP_BITS; i++) begin
            if (i < int'(p.span)) r = r & top[TOP_BITS-1-i];
        end
        return r;
    endfunction

    assign probe_locked_o = hit(prot, probe_addr_i[ADDR_W-1 -: TOP_BITS]);
    assign query_locked_o = hit(prot, query_addr_i[ADDR_W-1 -: TOP_BITS]);

    logic unused_low;
    assign unused_low = ^{probe_addr_i[LOW_W-1:0], query_addr_i[LOW_W-1:0]};

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(g) << SECTOR_AW;
        assign sector_locked_o[g] = hit(prot, BASE[ADDR_W-1 -: TOP_BITS]);
    end

endmodule

// File: rtl/srwp_cycle_timer.sv
module srwp_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
    import srwp_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int SECTOR_AW   = 12,
    parameter int BLOCK_AW    = 15,
    parameter int PROG_CYCLES = 64,
    parameter int SECT_CYCLES = 400,
    parameter int BLK_CYCLES  = 800,
    parameter int CHIP_CYCLES = 1600,
    parameter int STAT_CYCLES = 200
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic                wren_i,
    input  logic                wrdi_i,
    input  logic                prog_i,
    input  logic                sect_erase_i,
    input  logic                blk_erase_i,
    input  logic                chip_erase_i,
    input  logic                wrsr_i,
    input  logic [7:0]          wrsr_data_i,
    input  logic [ADDR_W-1:0]   cmd_addr_i,
    input  logic                cs_rise_i,
    input  logic                wp_n_i,
    input  logic [ADDR_W-1:0]   query_addr_i,
    output logic [7:0]          status_o,
    output logic                busy_o,
    output logic                addr_writable_o,
    output logic [(1 << (ADDR_W-SECTOR_AW))-1:0] sector_writable_o,
    output logic                cycle_start_o,
    output logic [2:0]          cycle_op_o,
    output logic [ADDR_W-1:0]   cycle_addr_o
);
    localparam int NUM_SECT = 1 << (ADDR_W - SECTOR_AW);
    localparam int MAX_A    = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
    localparam int MAX_B    = (BLK_CYCLES > CHIP_CYCLES) ? BLK_CYCLES : CHIP_CYCLES;
    localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC  = (MAX_C > STAT_CYCLES) ? MAX_C : STAT_CYCLES;
    localparam int CNT_W    = $clog2(MAX_CYC) + 1;
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECTOR_AW) - 1);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((1 << BLOCK_AW) - 1);

    state_e            state_q, state_d;
    sreg_t             sreg_q, pend_sr_q;
    op_e               pend_op_q, cmd_op;
    logic [ADDR_W-1:0] pend_addr_q, probe_addr;
    logic              wel_q, start_q;
    logic              hwlock, probe_locked, query_locked, grant, accept;
    logic              abort, launch, expired;
    logic [CNT_W-1:0]  load_val;
    logic [NUM_SECT-1:0] sector_locked;
    logic              unused_data;

    assign unused_data = ^{wrsr_data_i[4], wrsr_data_i[1:0]};
    assign hwlock      = !wp_n_i && sreg_q.wpen;

    // Command event to operation code, with a fixed priority.
    always_comb begin
        cmd_op = OP_NONE;
        if      (prog_i)       cmd_op = OP_PROG;
        else if (sect_erase_i) cmd_op = OP_SECT;
        else if (blk_erase_i)  cmd_op = OP_BLK;
        else if (chip_erase_i) cmd_op = OP_CHIP;
        else if (wrsr_i)       cmd_op = OP_STAT;
    end

    // Probe the highest address of the target region; locked ranges are top-aligned.
    always_comb begin
        unique case (cmd_op)
            OP_SECT: probe_addr = cmd_addr_i | SECT_MASK;
            OP_BLK:  probe_addr = cmd_addr_i | BLK_MASK;
            default: probe_addr = cmd_addr_i;
        endcase
    end

    srwp_lock_decode #(
        .ADDR_W   (ADDR_W),
        .SECTOR_AW(SECTOR_AW)
    ) u_lock (
        .code_i         ({sreg_q.bp4, sreg_q.bp3, sreg_q.bp1, sreg_q.bp0}),
        .probe_addr_i   (probe_addr),
        .query_addr_i   (query_addr_i),
        .probe_locked_o (probe_locked),
        .query_locked_o (query_locked),
        .sector_locked_o(sector_locked)
    );

    always_comb begin
        unique case (cmd_op)
            OP_PROG, OP_SECT, OP_BLK: grant = wel_q && !probe_locked;
            OP_CHIP:                  grant = wel_q;
            OP_STAT:                  grant = wel_q && !hwlock;
            default:                  grant = 1'b0;
        endcase
    end

    assign abort = (state_q == ST_ARMED) && (pend_op_q == OP_STAT) && hwlock;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (grant) state_d = ST_ARMED;
            ST_ARMED: begin
                if (abort)          state_d = ST_IDLE;
                else if (cs_rise_i) state_d = ST_CYCLE;
            end
            ST_CYCLE: if (expired) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign launch = (state_q == ST_ARMED) && (state_d == ST_CYCLE);
    assign accept = grant && ((state_q == ST_IDLE) ||
                              ((state_q == ST_ARMED) && !abort && !cs_rise_i));

    always_comb begin
        unique case (pend_op_q)
            OP_PROG: load_val = CNT_W'(PROG_CYCLES - 1);
            OP_SECT: load_val = CNT_W'(SECT_CYCLES - 1);
            OP_BLK:  load_val = CNT_W'(BLK_CYCLES - 1);
            OP_CHIP: load_val = CNT_W'(CHIP_CYCLES - 1);
            OP_STAT: load_val = CNT_W'(STAT_CYCLES - 1);
            default: load_val = '0;
        endcase
    end

    srwp_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .load_i    (launch),
        .load_val_i(load_val),
        .run_i     (state_q == ST_CYCLE),
        .expired_o (expired)
    );

    // State register.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // Registered datapath and outputs.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            wel_q       <= 1'b0;
            sreg_q      <= '0;
            pend_sr_q   <= '0;
            pend_op_q   <= OP_NONE;
            pend_addr_q <= '0;
            start_q     <= 1'b0;
        end else begin
            start_q <= launch;
            if (accept) begin
                pend_op_q   <= cmd_op;
                pend_addr_q <= cmd_addr_i;
                pend_sr_q   <= '{wpen: wrsr_data_i[7], bp4: wrsr_data_i[6],
                                 bp3: wrsr_data_i[5], bp1: wrsr_data_i[3],
                                 bp0: wrsr_data_i[2]};
            end
            if (state_q == ST_CYCLE) begin
                if (expired) begin
                    wel_q <= 1'b0;
                    if (pend_op_q == OP_STAT) sreg_q <= pend_sr_q;
                end
            end else if (wrdi_i) begin
                wel_q <= 1'b0;
            end else if (wren_i) begin
                wel_q <= 1'b1;
            end
        end
    end

    assign busy_o            = (state_q == ST_CYCLE);
    assign status_o          = busy_o ? 8'hFF :
                               {sreg_q.wpen, sreg_q.bp4, sreg_q.bp3, 1'b0,
                                sreg_q.bp1, sreg_q.bp0, wel_q, 1'b0};
    assign addr_writable_o   = !query_locked;
    assign sector_writable_o = ~sector_locked;
    assign cycle_start_o     = start_q;
    assign cycle_op_o        = pend_op_q;
    assign cycle_addr_o      = pend_addr_q;

endmodule

// File: rtl/srwp_checker.sv
module srwp_checker
    import srwp_pkg::*;
(
    input logic       clk_i,
    input logic       rst_n_i,
    input state_e     state_i,
    input logic       busy_i,
    input logic [7:0] status_i,
    input logic       wel_i,
    input logic       hwlock_i,
    input op_e        pend_op_i,
    input logic       cs_rise_i,
    input logic       wrdi_i,
    input logic       start_i
);

    assert_busy_reads_ff_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        busy_i |-> status_i == 8'hFF);

    assert_idle_spare_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !busy_i |-> (status_i[4] == 1'b0 && status_i[0] == 1'b0));

    assert_latch_clear_after_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(busy_i) |-> !wel_i);

    assert_launch_on_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(busy_i) |-> $past(cs_rise_i));

    assert_start_inside_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        start_i |-> busy_i);

    assert_clear_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wrdi_i && state_i == ST_IDLE) |=> !wel_i);

    assert_pending_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_i == ST_ARMED && pend_op_i == OP_STAT && hwlock_i) |=> state_i == ST_IDLE);

endmodule

bind sr_wp_unit srwp_checker u_chk (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .state_i  (state_q),
    .busy_i   (busy_o),
    .status_i (status_o),
    .wel_i    (wel_q),
    .hwlock_i (hwlock),
    .pend_op_i(pend_op_q),
    .cs_rise_i(cs_rise_i),
    .wrdi_i   (wrdi_i),
    .start_i  (cycle_start_o)
);

// File: tb/sim_sr_wp_unit.sv
module sim_sr_wp_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 17;
    localparam int SIZE = 1 << AW;
    localparam int NSEC = 32;
    localparam int PROG_C = 4;
    localparam int SECT_C = 6;
    localparam int BLK_C  = 7;
    localparam int CHIP_C = 9;
    localparam int STAT_C = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wren = 0, wrdi = 0, prog = 0, sect = 0, blk = 0, chip = 0, wrsr = 0, csr = 0;
    logic wp_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [AW-1:0] caddr = '0, qaddr = '0;

    logic [7:0]      status;
    logic            busy, awr, cstart;
    logic [NSEC-1:0] swr;
    logic [2:0]      cop;
    logic [AW-1:0]   caddr_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_wp_unit #(
        .ADDR_W(AW), .SECTOR_AW(12), .BLOCK_AW(15),
        .PROG_CYCLES(PROG_C), .SECT_CYCLES(SECT_C), .BLK_CYCLES(BLK_C),
        .CHIP_CYCLES(CHIP_C), .STAT_CYCLES(STAT_C)
    ) u0 (
        .clk_i(clk), .rst_n_i(rst_n),
        .wren_i(wren), .wrdi_i(wrdi), .prog_i(prog), .sect_erase_i(sect),
        .blk_erase_i(blk), .chip_erase_i(chip), .wrsr_i(wrsr), .wrsr_data_i(wdata),
        .cmd_addr_i(caddr), .cs_rise_i(csr), .wp_n_i(wp_n), .query_addr_i(qaddr),
        .status_o(status), .busy_o(busy), .addr_writable_o(awr),
        .sector_writable_o(swr), .cycle_start_o(cstart), .cycle_op_o(cop),
        .cycle_addr_o(caddr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // kind: 0 set latch, 1 clear latch, 2 program, 3 sector erase, 4 block erase,
    //       5 chip erase, 6 status write, 7 chip-select rise
    task automatic pulse(input int kind, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        caddr = a;
        wdata = d;
        case (kind)
            0: wren = 1'b1;
            1: wrdi = 1'b1;
            2: prog = 1'b1;
            3: sect = 1'b1;
            4: blk  = 1'b1;
            5: chip = 1'b1;
            6: wrsr = 1'b1;
            default: csr = 1'b1;
        endcase
        @(negedge clk);
        {wren, wrdi, prog, sect, blk, chip, wrsr, csr} = '0;
    endtask

    task automatic run_op(input int kind, input logic [AW-1:0] a, input logic [7:0] d,
                          input bit go, input int op, input int len, input bit drop_wp,
                          input string req);
        pulse(kind, a, d);
        pulse(7, '0, '0);
        check(req, busy, go);
        check(req, cstart, go);
        if (go) begin
            int n;
            check(req, cop, op);
            if (drop_wp) wp_n = 1'b0;
            n = 0;
            while (busy && n < 1000) begin
                n++;
                @(negedge clk);
            end
            check(req, n, len);
        end
    endtask

    function automatic int lock_base(input logic [3:0] c);
        int w;
        if      (c[1:0] == 2'b11) w = 0;
        else if (c[1:0] == 2'b10) w = 1;
        else if (c[1:0] == 2'b01) w = 2;
        else if (c[3:2] == 2'b11) w = 3;
        else if (c[3:2] == 2'b10) w = 4;
        else if (c[3:2] == 2'b01) w = 5;
        else return SIZE;
        return SIZE - (SIZE >> w);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", status, 8'h00);
        check("R1 busy", busy, 0);
        check("R1 sectors", swr, 32'hFFFF_FFFF);
        qaddr = 17'h1FFFF;
        #1 check("R1 query", awr, 1);

        // R3 latch set and clear
        pulse(0, '0, '0);
        check("R3 set", status, 8'h02);
        pulse(1, '0, '0);
        check("R3 clear", status, 8'h00);

        // R5 no latch, no cycle
        run_op(2, 17'h00010, '0, 0, 0, 0, 0, "R5 prog without latch");

        // R6 program cycle length and latch auto-clear (R5)
        pulse(0, '0, '0);
        run_op(2, 17'h00100, '0, 1, 1, PROG_C, 0, "R6 prog");
        check("R5 latch cleared", status, 8'h00);

        // R4 and R2: sweep every protect code
        for (int c = 0; c < 16; c++) begin
            logic [3:0] cb;
            logic [7:0] d;
            int base;
            cb = 4'(c);
            d = {1'b0, cb[3], cb[2], 1'b1, cb[1], cb[0], 2'b11};
            pulse(0, '0, '0);
            run_op(6, '0, d, 1, 5, STAT_C, 0, "R6 status write");
            check("R2 stored fields", status, {1'b0, cb[3], cb[2], 1'b0, cb[1], cb[0], 2'b00});
            base = lock_base(cb);
            for (int s = 0; s < NSEC; s++) begin
                int a;
                a = s * 4096 + 12'hABC;
                @(negedge clk);
                qaddr = AW'(a);
                #1;
                check("R4 query", awr, (a < base) ? 1 : 0);
                check("R4 sector", swr[s], (s * 4096 < base) ? 1 : 0);
            end
        end

        // code 0100: top 4 KB locked
        pulse(0, '0, '0);
        run_op(6, '0, 8'h20, 1, 5, STAT_C, 0, "R6 status write");
        check("R2 code 0100", status, 8'h20);

        // R8 region checks
        pulse(0, '0, '0);
        run_op(3, 17'h1F123, '0, 0, 0, 0, 0, "R8 sector erase locked");
        check("R8 latch kept", status, 8'h22);
        run_op(3, 17'h1E7FF, '0, 1, 2, SECT_C, 0, "R8 sector erase open");
        check("R6 sector addr", caddr_o, 17'h1E7FF);
        pulse(0, '0, '0);
        run_op(4, 17'h18000, '0, 0, 0, 0, 0, "R8 block erase partly locked");
        run_op(4, 17'h10005, '0, 1, 3, BLK_C, 0, "R8 block erase open");
        pulse(0, '0, '0);
        run_op(2, 17'h1FFFF, '0, 0, 0, 0, 0, "R8 prog locked");
        run_op(2, 17'h1EFFF, '0, 1, 1, PROG_C, 0, "R8 prog open");
        run_op(5, '0, '0, 0, 0, 0, 0, "R5 chip erase without latch");

        // R10 chip erase, R9 busy behaviour
        pulse(0, '0, '0);
        pulse(5, '0, '0);
        pulse(7, '0, '0);
        check("R10 chip start", busy, 1);
        check("R10 chip op", cop, 4);
        check("R10 sector map", swr, 32'h7FFF_FFFF);
        check("R9 status ff", status, 8'hFF);
        pulse(0, '0, '0);
        pulse(2, 17'h00200, '0);
        pulse(7, '0, '0);
        begin
            int n;
            n = 0;
            while (busy && n < 1000) begin
                n++;
                @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        check("R9 ignored during busy", busy, 0);
        check("R9 latch unchanged", status, 8'h20);

        // R7 hardware lock
        pulse(0, '0, '0);
        run_op(6, '0, 8'hA0, 1, 5, STAT_C, 0, "R7 set protect-enable");
        check("R7 enable stored", status, 8'hA0);
        wp_n = 1'b0;
        pulse(0, '0, '0);
        check("R3 set with pin low", status, 8'hA2);
        run_op(6, '0, 8'h00, 0, 0, 0, 0, "R7 refused under lock");
        check("R7 unchanged", status, 8'hA2);
        pulse(1, '0, '0);
        check("R3 clear with pin low", status, 8'hA0);
        wp_n = 1'b1;
        pulse(0, '0, '0);
        pulse(6, '0, 8'h00);
        @(negedge clk);
        wp_n = 1'b0;
        @(negedge clk);
        pulse(7, '0, '0);
        check("R7 pending cancelled", busy, 0);
        check("R7 status after cancel", status, 8'hA2);
        wp_n = 1'b1;
        run_op(6, '0, 8'h00, 1, 5, STAT_C, 1, "R7 pin drop after start");
        check("R7 write completed", status, 8'h00);
        pulse(0, '0, '0);
        run_op(6, '0, 8'h04, 1, 5, STAT_C, 0, "R7 pin ignored when disabled");
        check("R7 written with pin low", status, 8'h04);
        wp_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule